// File: doc/BRIEF.md
# Preemptible DMA Transfer Sequencer

This block is the data-moving core of a multi-channel DMA controller. It serves one channel per run. A start command names the channel and says why the run began: a fresh trigger or the resume of a paused run. The engine first reads that channel's three-word control record from a table in memory. It then clears the flag that caused the run. Next it moves data units one at a time from source to destination through a single valid/ready memory port, advancing the addresses and decrementing the unit count as it goes. The source can be read directly, or indirectly through a pointer that is fetched from the source address for every unit.

A run ends in one of two ways. When the count runs out, the engine writes the updated record back and raises an end pulse. The second way is preemption: after a unit, with units still left, a higher-priority hardware request is pending and the channel is not in single-transfer mode. The engine then writes its live addresses and remaining count back to the table and raises a pause pulse, so a later resume run continues where it stopped. Arbitration between channels and interrupt generation are handled outside this block.

Top module: `dma_seq_engine`

## Requirements
- R1: An accepted start reads three words at the record base, which is TABLE_BASE + channel × REC_STRIDE. The reads go to offsets 0 (source address), 4 (destination address) and 8 (control word), in that order. The control word holds count in bits [15:0], unit size in [17:16] (0 byte, 1 halfword, 2 word), source increment in [18], destination increment in [19], pointer source in [20], single mode in [21] and enable in [22].
- R2: One cycle after the control word is read, the engine gives a one-cycle pulse with flag_ch equal to the channel. The pulse is on trig_clr when start_resume was 0 and on pause_clr when start_resume was 1.
- R3: With the enable bit 0, the engine returns to idle after the flag-clear pulse. It makes no further memory access and gives no end or pause pulse.
- R4: With the pointer bit 1, each unit begins with a word read at the current source address, and the data is then read from the returned pointer.
- R5: Each unit reads the data at the unit size and then writes the same value to the destination at the unit size. running is 1 during every data access and 0 during every record access.
- R6: After each unit, an address whose increment bit is set advances by 1, 2 or 4 bytes according to unit size. An address whose increment bit is clear stays fixed. The count drops by one.
- R7: When the count reaches 0, the engine writes the source address, the destination address and the control word (count 0, other fields unchanged) back to offsets 0, 4 and 8. It then gives a one-cycle end_set pulse and returns to idle.
- R8: After a unit that leaves a nonzero count, if hi_pend is 1 and the record is not in single mode, the engine stops. It writes back the current addresses and the remaining count, then gives a one-cycle pause_set pulse.
- R9: A record in single mode ignores hi_pend and runs until the count reaches 0.
- R10: An enabled record whose loaded count is 0 moves no data. The engine writes the record back unchanged and gives end_set.
- R11: While mem_req is 1 and mem_ready is 0, the request, address, direction, size and write data hold steady.
- R12: A start asserted while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command, taken only when idle |
| start_ch | input | CH_W | Channel to serve |
| start_resume | input | 1 | 1 when the run resumes a paused channel |
| hi_pend | input | 1 | Higher-priority hardware request pending |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, zero-extended |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Engine not idle |
| running | output | 1 | Data units being moved |
| flag_ch | output | CH_W | Channel that the pulses refer to |
| trig_clr | output | 1 | Clear-trigger pulse |
| pause_clr | output | 1 | Clear-pause pulse |
| pause_set | output | 1 | Set-pause pulse |
| end_set | output | 1 | Set-end pulse |

## Verification
The bench builds the engine with NUM_CH = 4 and TABLE_BASE = 0x40, keeping REC_STRIDE = 16 and CNT_W = 16. The nonzero base and the two-bit channel field make any error in the record address visible as a wrong access. The four channels fit one record region of a 2 KB model memory, which leaves separate regions for sources, pointer slots, destinations and pointer targets. The memory model can insert wait states, so every kind of access is held across stalls. One run is preempted and then resumed, so the written-back live state is checked again on the second pass.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int CTL_BITS = 7;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } unit_size_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LD_SRC,
        ST_LD_DST,
        ST_LD_CTL,
        ST_CHECK,
        ST_PTR,
        ST_RD,
        ST_WR,
        ST_STEP,
        ST_WB_SRC,
        ST_WB_DST,
        ST_WB_CTL,
        ST_FIN
    } seq_state_e;

    // control fields, most significant first
    typedef struct packed {
        logic       en;
        logic       single;
        logic       src_ptr;
        logic       dst_inc;
        logic       src_inc;
        logic [1:0] size;
    } rec_ctl_t;

    function automatic logic [31:0] unit_mask(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: unit_mask = 32'h0000_00FF;
            SZ_HALF: unit_mask = 32'h0000_FFFF;
            default: unit_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
(
    input  logic [31:0] addr_i,
    input  logic [1:0]  size_i,
    input  logic        inc_i,
    output logic [31:0] addr_o
);
    logic [31:0] stride;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: stride = 32'd1;
            SZ_HALF: stride = 32'd2;
            default: stride = 32'd4;
        endcase
        addr_o = inc_i ? addr_i + stride : addr_i;
    end
endmodule

// File: rtl/dma_rec_codec.sv
module dma_rec_codec
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [31:0]      word_i,
    output rec_ctl_t         ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    input  rec_ctl_t         ctl_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [31:0]      word_o
);
    localparam int USED_W = CNT_W + CTL_BITS;

    logic unused_hi;

    assign cnt_o     = word_i[CNT_W-1:0];
    assign ctl_o     = rec_ctl_t'(word_i[CNT_W +: CTL_BITS]);
    assign unused_hi = ^word_i[31:USED_W];
    assign word_o    = 32'({ctl_i, cnt_i});
endmodule

// File: rtl/dma_seq_engine.sv
module dma_seq_engine
    import dma_seq_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter logic [31:0] TABLE_BASE = 32'h0000_0000,
    parameter int          REC_STRIDE = 16,
    parameter int          CNT_W      = 16,
    localparam int         CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] start_ch,
    input  logic            start_resume,
    input  logic            hi_pend,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            running,
    output logic [CH_W-1:0] flag_ch,
    output logic            trig_clr,
    output logic            pause_clr,
    output logic            pause_set,
    output logic            end_set
);
    localparam logic [31:0] OFS_SRC = 32'd0;
    localparam logic [31:0] OFS_DST = 32'd4;
    localparam logic [31:0] OFS_CTL = 32'd8;
    localparam int          NSTEP   = 2;

    typedef struct packed {
        seq_state_e       st;
        logic [CH_W-1:0]  ch;
        logic             resume;
        logic [31:0]      src;
        logic [31:0]      dst;
        logic [31:0]      ptr;
        logic [31:0]      buf_w;
        logic [CNT_W-1:0] cnt;
        rec_ctl_t         ctl;
        logic             paused;
    } eng_t;

    eng_t q, d;

    // record field codec
    rec_ctl_t         dec_ctl;
    logic [CNT_W-1:0] dec_cnt;
    logic [31:0]      enc_word;

    dma_rec_codec #(.CNT_W(CNT_W)) u_codec (
        .word_i (mem_rdata),
        .ctl_o  (dec_ctl),
        .cnt_o  (dec_cnt),
        .ctl_i  (q.ctl),
        .cnt_i  (q.cnt),
        .word_o (enc_word)
    );

    // address advance for source (0) and destination (1)
    logic [31:0] cur_a [NSTEP];
    logic        inc_a [NSTEP];
    logic [31:0] nxt_a [NSTEP];

    assign cur_a[0] = q.src;
    assign cur_a[1] = q.dst;
    assign inc_a[0] = q.ctl.src_inc;
    assign inc_a[1] = q.ctl.dst_inc;

    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        dma_addr_step u_step (
            .addr_i (cur_a[g]),
            .size_i (q.ctl.size),
            .inc_i  (inc_a[g]),
            .addr_o (nxt_a[g])
        );
    end

    logic [31:0] rec_base;
    assign rec_base = TABLE_BASE + 32'(q.ch) * 32'(REC_STRIDE);

    seq_state_e unit_entry;
    assign unit_entry = q.ctl.src_ptr ? ST_PTR : ST_RD;

    // next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.ch     = start_ch;
                    d.resume = start_resume;
                    d.st     = ST_LD_SRC;
                end
            end
            ST_LD_SRC: begin
                if (mem_ready) begin
                    d.src = mem_rdata;
                    d.st  = ST_LD_DST;
                end
            end
            ST_LD_DST: begin
                if (mem_ready) begin
                    d.dst = mem_rdata;
                    d.st  = ST_LD_CTL;
                end
            end
            ST_LD_CTL: begin
                if (mem_ready) begin
                    d.ctl = dec_ctl;
                    d.cnt = dec_cnt;
                    d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!q.ctl.en) begin
                    d.st = ST_IDLE;
                end else if (q.cnt == '0) begin
                    d.paused = 1'b0;
                    d.st     = ST_WB_SRC;
                end else begin
                    d.st = unit_entry;
                end
            end
            ST_PTR: begin
                if (mem_ready) begin
                    d.ptr = mem_rdata;
                    d.st  = ST_RD;
                end
            end
            ST_RD: begin
                if (mem_ready) begin
                    d.buf_w = mem_rdata & unit_mask(q.ctl.size);
                    d.st    = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) d.st = ST_STEP;
            end
            ST_STEP: begin
                d.src = nxt_a[0];
                d.dst = nxt_a[1];
                d.cnt = q.cnt - CNT_W'(1);
                if (q.cnt == CNT_W'(1)) begin
                    d.paused = 1'b0;
                    d.st     = ST_WB_SRC;
                end else if (hi_pend && !q.ctl.single) begin
                    d.paused = 1'b1;
                    d.st     = ST_WB_SRC;
                end else begin
                    d.st = unit_entry;
                end
            end
            ST_WB_SRC: begin
                if (mem_ready) d.st = ST_WB_DST;
            end
            ST_WB_DST: begin
                if (mem_ready) d.st = ST_WB_CTL;
            end
            ST_WB_CTL: begin
                if (mem_ready) d.st = ST_FIN;
            end
            ST_FIN: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // memory port drive
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rec_base;
        mem_size  = SZ_WORD;
        mem_wdata = '0;
        unique case (q.st)
            ST_LD_SRC: begin
                mem_req  = 1'b1;
                mem_addr = rec_base + OFS_SRC;
            end
            ST_LD_DST: begin
                mem_req  = 1'b1;
                mem_addr = rec_base + OFS_DST;
            end
            ST_LD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = rec_base + OFS_CTL;
            end
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = q.src;
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = q.ctl.src_ptr ? q.ptr : q.src;
                mem_size = q.ctl.size;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.dst;
                mem_size  = q.ctl.size;
                mem_wdata = q.buf_w;
            end
            ST_WB_SRC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rec_base + OFS_SRC;
                mem_wdata = q.src;
            end
            ST_WB_DST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rec_base + OFS_DST;
                mem_wdata = q.dst;
            end
            ST_WB_CTL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rec_base + OFS_CTL;
                mem_wdata = enc_word;
            end
            default: ;
        endcase
    end

    assign busy      = (q.st != ST_IDLE);
    assign running   = (q.st == ST_PTR) || (q.st == ST_RD) ||
                       (q.st == ST_WR)  || (q.st == ST_STEP);
    assign flag_ch   = q.ch;
    assign trig_clr  = (q.st == ST_CHECK) && !q.resume;
    assign pause_clr = (q.st == ST_CHECK) &&  q.resume;
    assign pause_set = (q.st == ST_FIN)   &&  q.paused;
    assign end_set   = (q.st == ST_FIN)   && !q.paused;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
            $stable(mem_we) && $stable(mem_size) && $stable(mem_wdata)));

    assert_clr_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clr || pause_clr) |-> ($past(mem_ready) && !busy == 1'b0));

    assert_one_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_clr, pause_clr, pause_set, end_set}));

    assert_abort_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_clr || pause_clr) && !q.ctl.en) |=> (!busy && !mem_req));

    assert_single_no_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pause_set |-> !q.ctl.single);

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STEP) |=> (q.cnt == $past(q.cnt) - CNT_W'(1)));

    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mem_req && !mem_we && mem_ready && q.st == ST_RD)
            |=> (mem_req && mem_we && running));

    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(q.st == ST_FIN)) |=> ($stable(flag_ch)));

    assert_end_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        end_set |-> (q.cnt == '0));
endmodule

// File: tb/dma_seq_engine_test.sv
module dma_seq_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int CHW        = 2;
    localparam logic [31:0] TBASE = 32'h40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [CHW-1:0] start_ch = '0;
    logic           start_resume = 1'b0;
    logic           hi_pend = 1'b0;
    logic           mem_req, mem_we, mem_ready;
    logic [31:0]    mem_addr, mem_wdata, mem_rdata;
    logic [1:0]     mem_size;
    logic           busy, running, trig_clr, pause_clr, pause_set, end_set;
    logic [CHW-1:0] flag_ch;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_seq_engine #(.NUM_CH(NCH), .TABLE_BASE(TBASE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch),
        .start_resume(start_resume), .hi_pend(hi_pend),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .running(running),
        .flag_ch(flag_ch), .trig_clr(trig_clr), .pause_clr(pause_clr),
        .pause_set(pause_set), .end_set(end_set)
    );

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  sz;
        logic [31:0] data;
    } acc_t;

    acc_t  expq[$];
    string tagq[$];

    logic [7:0] mem [0:2047];
    bit  stall = 1'b0;
    int  cyc = 0;
    int  n_trig, n_pclr, n_pset, n_end;
    logic [CHW-1:0] seen_ch;
    int  last_n;
    logic [31:0] last_s, last_d;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] r = '0;
        for (int i = 0; i < nbytes(sz); i++) r[8*i +: 8] = 8'(a + 32'(i)) ^ 8'h3C;
        return r;
    endfunction

    function automatic logic [31:0] mrd(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] r = '0;
        for (int i = 0; i < nbytes(sz); i++) r[8*i +: 8] = mem[int'((a + 32'(i)) & 32'h7FF)];
        return r;
    endfunction

    task automatic mwr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] v);
        for (int i = 0; i < nbytes(sz); i++) mem[int'((a + 32'(i)) & 32'h7FF)] = v[8*i +: 8];
    endtask

    task automatic push(input bit we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] dv, input string tag);
        acc_t e;
        e.we = we; e.addr = a; e.sz = sz; e.data = dv;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        mem_ready = 1'b0;
        if (rst_n && mem_req) begin
            if (!(stall && (cyc % 3 == 0))) begin
                acc_t  e;
                string tg;
                mem_ready = 1'b1;
                if (expq.size() == 0) begin
                    check(1'b0, "R1/R12", "unexpected access", mem_addr, 32'h0);
                end else begin
                    e  = expq.pop_front();
                    tg = tagq.pop_front();
                    check(mem_we == e.we && mem_addr == e.addr && mem_size == e.sz,
                          tg, "access addr", mem_addr, e.addr);
                    if (e.we) check(mem_wdata == e.data, tg, "write data", mem_wdata, e.data);
                end
                if (mem_we) mwr(mem_addr, mem_size, mem_wdata);
                else        mem_rdata = mrd(mem_addr, mem_size);
            end
            // R5: running during data accesses only
            if (mem_addr >= 32'h200 && !running)
                check(1'b0, "R5", "running low on data access", 32'(running), 32'h1);
            if (mem_addr < 32'h200 && running)
                check(1'b0, "R5", "running high on record access", 32'(running), 32'h0);
        end
        if (trig_clr)  begin n_trig++; seen_ch = flag_ch; end
        if (pause_clr) begin n_pclr++; seen_ch = flag_ch; end
        if (pause_set) n_pset++;
        if (end_set)   n_end++;
    end

    task automatic run_xfer(input int ch, input bit resume, input logic [31:0] src,
                            input logic [31:0] dst, input int cnt, input logic [1:0] sz,
                            input bit sinc, input bit dinc, input bit ptr,
                            input bit single, input bit en, input bit hi,
                            input bit poke, input string tag);
        logic [31:0] base, ctlw, s, d, ra, pv, wbw;
        int n, u, step, wait_c;
        base = TBASE + 32'(ch) * 32'd16;
        ctlw = {9'b0, en, single, ptr, dinc, sinc, sz, 16'(cnt)};
        mwr(base, 2'd2, src);
        mwr(base + 4, 2'd2, dst);
        mwr(base + 8, 2'd2, ctlw);
        push(0, base,     2'd2, 0, "R1");
        push(0, base + 4, 2'd2, 0, "R1");
        push(0, base + 8, 2'd2, 0, "R1");
        s = src; d = dst; n = cnt; u = 0; step = nbytes(sz);
        if (en) begin
            while (n > 0) begin
                ra = s;
                if (ptr) begin
                    pv = 32'h600 + 32'(u) * 32'd8;
                    mwr(s, 2'd2, pv);
                    push(0, s, 2'd2, 0, "R4");
                    ra = pv;
                end
                push(0, ra, sz, 0, tag);
                push(1, d, sz, pat(ra, sz), tag);
                if (sinc) s = s + 32'(step);
                if (dinc) d = d + 32'(step);
                n--; u++;
                if (n == 0) break;
                if (hi && !single) break;
            end
            wbw = {9'b0, en, single, ptr, dinc, sinc, sz, 16'(n)};
            push(1, base,     2'd2, s,   (n > 0) ? "R8" : "R7");
            push(1, base + 4, 2'd2, d,   (n > 0) ? "R8" : "R7");
            push(1, base + 8, 2'd2, wbw, (cnt == 0) ? "R10" : "R7");
        end
        n_trig = 0; n_pclr = 0; n_pset = 0; n_end = 0; seen_ch = '0;
        hi_pend = hi;
        @(negedge clk);
        start = 1'b1; start_ch = CHW'(ch); start_resume = resume;
        @(negedge clk);
        start = 1'b0;
        wait_c = 0;
        while (busy && wait_c < 5000) begin
            @(negedge clk);
            wait_c++;
            if (poke && wait_c == 6) begin
                start = 1'b1; start_ch = CHW'(ch + 1); start_resume = 1'b0;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(wait_c < 5000, tag, "run finished", 32'(wait_c), 32'd0);
        repeat (2) @(negedge clk);
        check(expq.size() == 0, tag, "all expected accesses made", 32'(expq.size()), 32'd0);
        expq.delete(); tagq.delete();
        check(n_trig == int'(!resume), "R2", "trig_clr pulses", 32'(n_trig), 32'(!resume));
        check(n_pclr == int'(resume), "R2", "pause_clr pulses", 32'(n_pclr), 32'(resume));
        check(seen_ch == CHW'(ch), "R2", "flag channel", 32'(seen_ch), 32'(ch));
        check(n_end == int'(en && n == 0), en ? "R7" : "R3", "end pulses",
              32'(n_end), 32'(en && n == 0));
        check(n_pset == int'(en && n > 0), en ? "R8" : "R3", "pause pulses",
              32'(n_pset), 32'(en && n > 0));
        if (en) begin
            check(mrd(base, 2'd2) == s, "R6", "record source", mrd(base, 2'd2), s);
            check(mrd(base + 4, 2'd2) == d, "R6", "record dest", mrd(base + 4, 2'd2), d);
            check(mrd(base + 8, 2'd2) == wbw, "R7", "record control",
                  mrd(base + 8, 2'd2), wbw);
        end
        last_n = n; last_s = s; last_d = d;
        hi_pend = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'(i) ^ 8'h3C;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !running, "R3", "reset state idle",
              {29'b0, busy, mem_req, running}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // word units, both addresses advance
        run_xfer(0, 0, 32'h200, 32'h400, 3, 2'd2, 1, 1, 0, 0, 1, 0, 0, "R5");
        // byte units, fixed source, wait states
        stall = 1'b1;
        run_xfer(1, 0, 32'h213, 32'h440, 4, 2'd0, 0, 1, 0, 0, 1, 0, 0, "R6");
        // halfword units, fixed destination
        run_xfer(2, 0, 32'h252, 32'h480, 2, 2'd1, 1, 0, 0, 0, 1, 0, 0, "R11");
        stall = 1'b0;
        // pointer source
        run_xfer(3, 0, 32'h380, 32'h4C0, 3, 2'd2, 1, 1, 1, 0, 1, 0, 0, "R4");
        // disabled record aborts
        run_xfer(1, 0, 32'h200, 32'h500, 5, 2'd2, 1, 1, 0, 0, 0, 1, 0, "R3");
        // zero count
        run_xfer(2, 0, 32'h200, 32'h520, 0, 2'd2, 1, 1, 0, 0, 1, 0, 0, "R10");
        // preempted after one unit, then resumed
        stall = 1'b1;
        run_xfer(0, 0, 32'h2A0, 32'h540, 4, 2'd1, 1, 1, 0, 0, 1, 1, 0, "R8");
        check(last_n == 3, "R8", "remaining count", 32'(last_n), 32'd3);
        run_xfer(0, 1, last_s, last_d, last_n, 2'd1, 1, 1, 0, 0, 1, 0, 0, "R8");
        stall = 1'b0;
        // single mode ignores the higher-priority request
        run_xfer(1, 0, 32'h2C0, 32'h580, 3, 2'd2, 1, 1, 0, 1, 1, 1, 0, "R9");
        // start while busy is ignored
        run_xfer(2, 0, 32'h2E0, 32'h5C0, 3, 2'd2, 1, 1, 0, 0, 1, 0, 1, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule